// File: doc/BRIEF.md
# In-Order Completion Reorder Buffer

This block hands out tags to work items as they start. It takes back results labelled with those tags in any order, and releases the results strictly in the order the tags were handed out. A requester asks for a tag on the issue handshake and gets the buffer's current input index. An execution engine, such as a multi-cycle memory lookup whose replies can return out of order, later writes its result with that tag on the completion port. A consumer drains results from the output handshake. The oldest outstanding tag always sits at the head. The output stays stalled until that head slot has been written, even if younger slots are already complete.

Storage is a ring of `SLOTS` entries, each with a data word and a valid bit. An input index, an output index and an occupancy count control the ring. All three start at zero and both indices wrap modulo `SLOTS`, which must be a power of two. An occupancy state machine tracks the count and drives the ready and valid qualifiers. It has three states:
- `OCC_EMPTY`: no tag is outstanding.
- `OCC_PARTIAL`: some tags are outstanding and a free slot remains.
- `OCC_FULL`: every slot holds an outstanding tag.

Its transitions are:
- `EMPTY→PARTIAL` on an issue.
- `PARTIAL→FULL` on an issue alone that fills the last slot.
- `PARTIAL→EMPTY` on a removal alone that frees the last outstanding slot.
- `FULL→PARTIAL` on a removal.
- `EMPTY→FULL` and `FULL→EMPTY` occur only when `SLOTS` is 1.
- Every other case holds the state, including a simultaneous issue and removal.

Top module: `cmpl_reorder_buf`

## Requirements
- R1: After reset `tok_ready` is 1, `res_valid` is 0 and `tok_tag` is 0.
- R2: An issue happens on a clock edge where `tok_req` and `tok_ready` are both 1. The tag granted is the value on `tok_tag` in that cycle, and the tag after it is that value plus one, modulo `SLOTS`.
- R3: `tok_ready` is 0 exactly when `SLOTS` tags are outstanding. A `tok_req` seen while `tok_ready` is 0 grants nothing, and `tok_tag` keeps its value.
- R4: A completion (`cmp_valid` 1) stores `cmp_data` in the slot numbered `cmp_tag` and marks that slot valid.
- R5: `res_valid` is 1 only when at least one tag is outstanding and the slot of the oldest outstanding tag is valid. Completions of younger tags alone never raise it.
- R6: A removal happens on an edge where `res_valid` and `res_ready` are both 1. `res_data` carries the oldest outstanding tag's data, so results leave in issue order, and the removal frees that tag.
- R7: An issue and a removal on the same edge leave the number of outstanding tags unchanged.
- R8: A completion written to the head slot drives `res_valid` and `res_data` from the cycle after its edge, not in the same cycle.
- R9: Issuing a tag clears its slot's valid bit, so stale data from an earlier use of the slot is never released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_req | input | 1 | Request for a new tag |
| tok_ready | output | 1 | A free slot exists; a tag can be granted |
| tok_tag | output | $clog2(SLOTS) | Tag granted by an issue in this cycle |
| cmp_valid | input | 1 | Completion write strobe |
| cmp_tag | input | $clog2(SLOTS) | Slot addressed by the completion |
| cmp_data | input | DATA_W | Result data of the completion |
| res_valid | output | 1 | The oldest outstanding result is ready |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | DATA_W | Oldest outstanding result |

## Verification
A wrong input index appears on `tok_tag` on the next grant. A wrong output index or valid bit appears on `res_valid` or `res_data` as soon as the affected slot reaches the head, which can take up to `SLOTS` removals. A count that drifts is visible through `tok_ready`, either too early or too late at the full boundary. Such drift can also show as `res_valid` asserted with nothing outstanding. The bench therefore compares all outputs against a queue model on every cycle, under random traffic long enough to wrap the ring many times.

// File: rtl/crb_pkg.sv
package crb_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;

endpackage

// File: rtl/crb_index_ctrl.sv
module crb_index_ctrl
    import crb_pkg::*;
#(
    parameter int SLOTS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         issue_fire,
    input  logic                         take_fire,
    output logic [$clog2(SLOTS)-1:0]     in_idx,
    output logic [$clog2(SLOTS)-1:0]     out_idx,
    output logic [$clog2(SLOTS+1)-1:0]   count,
    output occ_state_e                   occ,
    output logic                         is_empty,
    output logic                         is_full
);

    localparam int IDX_W = $clog2(SLOTS);
    localparam int CNT_W = $clog2(SLOTS+1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOTS - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

    logic [IDX_W-1:0] in_q, out_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    occ_state_e       occ_q, occ_d;

    // occupancy count next value
    always_comb begin
        cnt_d = cnt_q;
        unique case ({issue_fire, take_fire})
            2'b10:   cnt_d = cnt_q + CNT_ONE;
            2'b01:   cnt_d = cnt_q - CNT_ONE;
            default: cnt_d = cnt_q;
        endcase
    end

    // occupancy state transitions
    always_comb begin
        occ_d = occ_q;
        unique case (occ_q)
            OCC_EMPTY: begin
                if (issue_fire)
                    occ_d = (SLOTS == 1) ? OCC_FULL : OCC_PARTIAL;
            end
            OCC_PARTIAL: begin
                if (issue_fire && !take_fire && cnt_q == CNT_LAST)
                    occ_d = OCC_FULL;
                else if (take_fire && !issue_fire && cnt_q == CNT_ONE)
                    occ_d = OCC_EMPTY;
            end
            OCC_FULL: begin
                if (take_fire)
                    occ_d = (SLOTS == 1) ? OCC_EMPTY : OCC_PARTIAL;
            end
            default: occ_d = OCC_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= OCC_EMPTY;
            cnt_q <= '0;
            in_q  <= '0;
            out_q <= '0;
        end else begin
            occ_q <= occ_d;
            cnt_q <= cnt_d;
            if (issue_fire) in_q  <= in_q + IDX_ONE;
            if (take_fire)  out_q <= out_q + IDX_ONE;
        end
    end

    // state-decoded outputs
    always_comb begin
        is_empty = 1'b0;
        is_full  = 1'b0;
        unique case (occ_q)
            OCC_EMPTY:   is_empty = 1'b1;
            OCC_PARTIAL: ;
            OCC_FULL:    is_full  = 1'b1;
            default:     is_empty = 1'b1;
        endcase
    end

    assign in_idx  = in_q;
    assign out_idx = out_q;
    assign count   = cnt_q;
    assign occ     = occ_q;

endmodule

// File: rtl/crb_slot_array.sv
module crb_slot_array #(
    parameter int DATA_W = 16,
    parameter int SLOTS  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr_en,
    input  logic [$clog2(SLOTS)-1:0]  clr_idx,
    input  logic                      wr_en,
    input  logic [$clog2(SLOTS)-1:0]  wr_idx,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [$clog2(SLOTS)-1:0]  rd_idx,
    output logic                      rd_valid,
    output logic [DATA_W-1:0]         rd_data
);

    logic              vld_q [SLOTS];
    logic [DATA_W-1:0] dat_q [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic hit_clr, hit_wr;
        assign hit_clr = clr_en && (clr_idx == s[$clog2(SLOTS)-1:0]);
        assign hit_wr  = wr_en  && (wr_idx  == s[$clog2(SLOTS)-1:0]);

        // an issue clearing the slot takes priority over a write to it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[s] <= 1'b0;
                dat_q[s] <= '0;
            end else if (hit_clr) begin
                vld_q[s] <= 1'b0;
            end else if (hit_wr) begin
                vld_q[s] <= 1'b1;
                dat_q[s] <= wr_data;
            end
        end
    end

    assign rd_valid = vld_q[rd_idx];
    assign rd_data  = dat_q[rd_idx];

endmodule

// File: rtl/cmpl_reorder_buf.sv
module cmpl_reorder_buf
    import crb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SLOTS  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tok_req,
    output logic                      tok_ready,
    output logic [$clog2(SLOTS)-1:0]  tok_tag,
    input  logic                      cmp_valid,
    input  logic [$clog2(SLOTS)-1:0]  cmp_tag,
    input  logic [DATA_W-1:0]         cmp_data,
    output logic                      res_valid,
    input  logic                      res_ready,
    output logic [DATA_W-1:0]         res_data
);

    localparam int IDX_W = $clog2(SLOTS);
    localparam int CNT_W = $clog2(SLOTS+1);

    logic             issue_fire, take_fire;
    logic [IDX_W-1:0] in_idx, out_idx;
    logic [CNT_W-1:0] count;
    occ_state_e       occ;
    logic             is_empty, is_full;
    logic             head_vld;
    logic [DATA_W-1:0] head_dat;

    assign tok_ready  = !is_full;
    assign issue_fire = tok_req && tok_ready;
    assign res_valid  = !is_empty && head_vld;
    assign take_fire  = res_valid && res_ready;
    assign tok_tag    = in_idx;
    assign res_data   = head_dat;

    crb_index_ctrl #(.SLOTS(SLOTS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_fire (issue_fire),
        .take_fire  (take_fire),
        .in_idx     (in_idx),
        .out_idx    (out_idx),
        .count      (count),
        .occ        (occ),
        .is_empty   (is_empty),
        .is_full    (is_full)
    );

    crb_slot_array #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (issue_fire),
        .clr_idx  (in_idx),
        .wr_en    (cmp_valid),
        .wr_idx   (cmp_tag),
        .wr_data  (cmp_data),
        .rd_idx   (out_idx),
        .rd_valid (head_vld),
        .rd_data  (head_dat)
    );

endmodule

// File: rtl/crb_checker.sv
module crb_checker #(
    parameter int DATA_W = 16,
    parameter int SLOTS  = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tok_req,
    input logic                       tok_ready,
    input logic [$clog2(SLOTS)-1:0]   tok_tag,
    input logic                       res_valid,
    input logic                       res_ready,
    input logic [$clog2(SLOTS+1)-1:0] count
);

    localparam int IDX_W = $clog2(SLOTS);
    localparam int CNT_W = $clog2(SLOTS+1);

    logic [IDX_W-1:0] tag_plus;
    logic             iss, tak;
    assign tag_plus = tok_tag + IDX_W'(1);
    assign iss = tok_req && tok_ready;
    assign tak = res_valid && res_ready;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(SLOTS));

    assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(SLOTS)) |-> !tok_ready);

    assert_stall_keeps_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !iss |=> $stable(tok_tag));

    assert_tag_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        iss |=> (tok_tag == $past(tag_plus)));

    assert_empty_no_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !res_valid);

    assert_take_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tak && !iss) |=> (count == $past(count) - CNT_W'(1)));

    assert_pair_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tak && iss) |=> $stable(count));

endmodule

bind cmpl_reorder_buf crb_checker #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_crb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_req   (tok_req),
    .tok_ready (tok_ready),
    .tok_tag   (tok_tag),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .count     (count)
);

// File: tb/cmpl_reorder_buf_bench.sv
module cmpl_reorder_buf_bench;

    localparam int DW    = 16;
    localparam int NS    = 8;
    localparam int IW    = $clog2(NS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tok_req = 1'b0;
    logic          tok_ready;
    logic [IW-1:0] tok_tag;
    logic          cmp_valid = 1'b0;
    logic [IW-1:0] cmp_tag = '0;
    logic [DW-1:0] cmp_data = '0;
    logic          res_valid;
    logic          res_ready = 1'b0;
    logic [DW-1:0] res_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    cmpl_reorder_buf #(.DATA_W(DW), .SLOTS(NS)) u_cmpl_reorder_buf (
        .clk(clk), .rst_n(rst_n),
        .tok_req(tok_req), .tok_ready(tok_ready), .tok_tag(tok_tag),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
    );

    // ---------------- reference model ----------------
    int            order_q[$];   // outstanding tags, oldest first
    int            pend_q[$];    // issued, not yet completed
    int            next_tag;
    bit            m_vld [NS];
    logic [DW-1:0] m_dat [NS];

    function automatic bit exp_ready();
        return order_q.size() < NS;
    endfunction
    function automatic bit exp_rvalid();
        return order_q.size() > 0 && m_vld[order_q[0]];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            order_q.delete(); pend_q.delete(); next_tag = 0;
            for (int i = 0; i < NS; i++) begin m_vld[i] = 0; m_dat[i] = '0; end
        end else begin
            bit tf, rf;
            tf = tok_req && exp_ready();
            rf = res_ready && exp_rvalid();
            if (cmp_valid) begin
                m_vld[cmp_tag] = 1; m_dat[cmp_tag] = cmp_data;
                foreach (pend_q[i]) if (pend_q[i] == int'(cmp_tag)) begin
                    pend_q.delete(i); break;
                end
            end
            if (rf) void'(order_q.pop_front());
            if (tf) begin
                m_vld[next_tag] = 0;
                order_q.push_back(next_tag);
                pend_q.push_back(next_tag);
                next_tag = (next_tag + 1) % NS;
            end
        end
    end

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        #6;
        if (rst_n && !finished) begin
            chk("R3", "tok_ready", tok_ready, exp_ready());
            chk("R2", "tok_tag", tok_tag, next_tag);
            chk("R5", "res_valid", res_valid, exp_rvalid());
            if (exp_rvalid()) chk("R6", "res_data", res_data, m_dat[order_q[0]]);
        end
    end

    // drive at negedge; outputs observed afterwards reflect edges before this one
    task automatic cyc(bit rq, bit rr, bit cv, int tg, logic [DW-1:0] dt);
        @(negedge clk);
        tok_req = rq; res_ready = rr; cmp_valid = cv;
        cmp_tag = IW'(tg); cmp_data = dt;
        #5;
    endtask

    task automatic fill(output int n);
        n = 0;
        for (int k = 0; k < 4 * NS; k++) begin
            cyc(1, 0, 0, 0, '0);
            if (!tok_ready) break;
            n++;
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        // R1 reset state
        chk("R1", "tok_ready", tok_ready, 1);
        chk("R1", "res_valid", res_valid, 0);
        chk("R1", "tok_tag", tok_tag, 0);

        // issue tags 0,1,2 ; complete out of order
        for (int k = 0; k < 3; k++) cyc(1, 0, 0, 0, '0);
        cyc(0, 0, 1, 2, 16'hC002);
        cyc(0, 0, 1, 1, 16'hC001);
        cyc(0, 0, 0, 0, '0);
        chk("R5", "head pending, younger done", res_valid, 0);
        cyc(0, 0, 1, 0, 16'hC000);
        chk("R8", "same-cycle completion hidden", res_valid, 0);
        cyc(0, 0, 0, 0, '0);
        chk("R8", "completion visible next cycle", res_valid, 1);
        chk("R4", "head data", res_data, 16'hC000);
        cyc(0, 1, 0, 0, '0); chk("R6", "order 0", res_data, 16'hC000);
        cyc(0, 1, 0, 0, '0); chk("R6", "order 1", res_data, 16'hC001);
        cyc(0, 1, 0, 0, '0); chk("R6", "order 2", res_data, 16'hC002);
        cyc(0, 0, 0, 0, '0); chk("R6", "drained", res_valid, 0);

        // fill to capacity, then request while full
        fill(n);
        chk("R3", "grants until full", n, NS);
        cyc(1, 0, 0, 0, '0);
        chk("R3", "ready low while full", tok_ready, 0);
        chk("R3", "tag held while full", tok_tag, 3);

        // complete and drain tags 3..7; head moves to reissued slot 0
        for (int t = 3; t < NS; t++) cyc(0, 0, 1, t, 16'(16'hA000 + t));
        for (int t = 3; t < NS; t++) begin
            cyc(0, 1, 0, 0, '0);
            chk("R6", "wrapped order", res_data, 16'hA000 + t);
        end
        cyc(0, 0, 0, 0, '0);
        chk("R9", "stale slot not released", res_valid, 0);

        // simultaneous issue and removal keeps occupancy
        cyc(0, 0, 1, 0, 16'hB000);
        cyc(0, 0, 0, 0, '0);
        cyc(1, 1, 0, 0, '0);
        chk("R7", "pair cycle head data", res_data, 16'hB000);
        fill(n);
        chk("R7", "free slots after pair", n, NS - 3);

        // random traffic
        for (int k = 0; k < 6000; k++) begin
            bit cv; int tg;
            cv = 0; tg = 0;
            if (pend_q.size() > 0 && ($urandom % 3) != 0) begin
                cv = 1; tg = pend_q[$urandom % pend_q.size()];
            end
            cyc(($urandom % 3) != 0, ($urandom % 4) != 0, cv, tg, 16'($urandom));
        end
        cyc(0, 0, 0, 0, '0);
        @(negedge clk); #8;
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule